// File: doc/BRIEF.md
# Two-Requester Priority Grant Arbiter

The block decides, every clock cycle, which of two requesters may use a shared memory. The first requester has strict priority. Each cycle in which its request line is sampled high opens a grant window of fixed length, two cycles by default. A request seen while a window is already open starts the count again, so the window ends two cycles after the most recent request.

Whenever no window is open, the grant parks on the second requester. It does not wait for that requester to ask. The request line of the second requester therefore never changes the grants.

Both grants come from flip-flops, so neither depends combinationally on a request. A registered flag reports it if both grants were ever seen high together.

Top module: `prio_grant_arb`

## Requirements
- R1: While synchronous active-high reset is sampled high, the next edge sets gnt_hi to 0, gnt_lo to 1 and excl_err to 0.
- R2: When req_hi is sampled high at an edge, gnt_hi is 1 in each of the two cycles that follow that edge (WIN_LEN=2).
- R3: gnt_hi and gnt_lo are never both 1.
- R4: In every cycle exactly one grant is 1: whenever gnt_hi is 0, gnt_lo is 1.
- R5: If req_hi is sampled low at two consecutive edges, gnt_hi is 0 in the cycle after the second of those edges.
- R6: A req_hi sampled during an open window restarts the window, so gnt_hi stays 1 for two cycles after the latest req_hi.
- R7: req_lo has no effect on gnt_hi or gnt_lo. The second requester is granted exactly when no window is open.
- R8: The grants change only at rising clock edges. Changing req_hi or req_lo between edges leaves them unchanged.
- R9: excl_err is a registered flag that is 1 only one cycle after gnt_hi and gnt_lo were both 1. It stays 0 when the design works correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_hi | input | 1 | Request from the priority requester |
| req_lo | input | 1 | Request from the second requester |
| gnt_hi | output | 1 | Registered grant to the priority requester |
| gnt_lo | output | 1 | Registered grant to the second requester |
| excl_err | output | 1 | Registered flag: both grants were seen high together |

## Verification
The embedded properties check the following on every cycle:
- the grants are exclusive and one of them is always high;
- a sampled priority request is followed by two high cycles of gnt_hi;
- two quiet cycles of req_hi close the window;
- with no window open, a low-priority request finds its grant;
- the error flag never rises.

The bench's reference model covers what a local property cannot express:
- the exact length of a window after repeated and back-to-back requests;
- a reset arriving in the middle of a window;
- the grants staying steady while the requests toggle between edges.

// File: rtl/prio_grant_arb.sv
module prio_grant_arb #(
  parameter int WIN_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_hi,
  input  logic req_lo,
  output logic gnt_hi,
  output logic gnt_lo,
  output logic excl_err
);

  localparam int CW = (WIN_LEN < 2) ? 1 : $clog2(WIN_LEN + 1);
  localparam logic [CW-1:0] RELOAD = CW'(WIN_LEN - 1);

  logic [CW-1:0] left;
  logic          win_open;

  assign win_open = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left     <= '0;
      gnt_hi   <= 1'b0;
      gnt_lo   <= 1'b1;
      excl_err <= 1'b0;
    end else begin
      excl_err <= gnt_hi & gnt_lo;
      if (req_hi) begin
        left   <= RELOAD;
        gnt_hi <= 1'b1;
        gnt_lo <= 1'b0;
      end else if (win_open) begin
        left   <= left - 1'b1;
        gnt_hi <= 1'b1;
        gnt_lo <= 1'b0;
      end else begin
        gnt_hi <= 1'b0;
        gnt_lo <= 1'b1;
      end
    end
  end

  // R2
  hi_grant_chk: assert property (@(posedge clk) disable iff (rst)
    req_hi |=> gnt_hi);

  // R3
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gnt_hi && gnt_lo));

  // R4
  park_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_hi || gnt_lo);

  // R7
  lo_served_chk: assert property (@(posedge clk) disable iff (rst)
    (req_lo && !req_hi && !win_open) |=> gnt_lo);

  // R9
  no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !excl_err);

  generate
    if (WIN_LEN == 2) begin : g_two
      // R2
      hi_two_chk: assert property (@(posedge clk) disable iff (rst)
        req_hi |=> gnt_hi ##1 gnt_hi);
      // R5
      quiet_close_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_hi ##1 !req_hi) |=> !gnt_hi);
    end
  endgenerate

endmodule

// File: tb/tb_prio_grant_arb.sv
module tb_prio_grant_arb;
  localparam int WIN = 2;

  logic clk = 1'b0;
  logic rst, req_hi, req_lo;
  logic gnt_hi, gnt_lo, excl_err;
  int   total = 0;
  int   bad = 0;
  int   rem = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  prio_grant_arb #(.WIN_LEN(WIN)) dut (
    .clk(clk), .rst(rst), .req_hi(req_hi), .req_lo(req_lo),
    .gnt_hi(gnt_hi), .gnt_lo(gnt_lo), .excl_err(excl_err)
  );

  always @(posedge clk) begin
    if (rst) rem = 0;
    else if (req_hi) rem = WIN;
    else if (rem > 0) rem = rem - 1;
  end

  task automatic chk(input string tag);
    logic eh;
    eh = (rem > 0);
    total++;
    if (gnt_hi !== eh || gnt_lo !== !eh || excl_err !== 1'b0) begin
      bad++;
      $display("FAIL %s: hi/lo/err=%b%b%b expected %b%b0", tag,
               gnt_hi, gnt_lo, excl_err, eh, !eh);
    end
  endtask

  task automatic step(input logic h, input logic l, input logic r, input string tag);
    @(negedge clk);
    chk(tag);
    req_hi = h; req_lo = l; rst = r;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    rst = 1; req_hi = 1; req_lo = 1;
    repeat (3) @(posedge clk);
    step(0, 0, 0, "R1");
    // single pulse, then quiet
    step(1, 0, 0, "R1");
    for (int i = 0; i < 5; i++) step(0, 0, 0, (i < 2) ? "R2" : "R5");
    // retrigger inside an open window
    step(1, 0, 0, "R6");
    step(0, 0, 0, "R6");
    step(1, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R6");
    // long held request
    for (int i = 0; i < 5; i++) step(1, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R5");
    // req_lo toggling, idle and during window
    for (int i = 0; i < 6; i++) step(0, i[0], 0, "R7");
    step(1, 1, 0, "R7");
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R7");
    // mid-cycle input changes must not move grants
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, "R8");
      #3 req_hi = 1; req_lo = 1;
      #3 chk("R8");
      req_hi = 0; req_lo = 0;
    end
    // reset in the middle of a window
    step(1, 0, 0, "R1");
    step(0, 0, 1, "R1");
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R1");
    // pseudo-random pattern
    lf = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[0] & lf[3], lf[1], 1'b0, "R3");
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R9");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule